// File: doc/BRIEF.md
# Periodic Tick Timer with Match Counter

The block is a periodic tick timer that software uses as a scheduler clock. A counter advances by one on every cycle in which an external rate strobe is high and counting is enabled. The counter value is compared with a compare register. When the incremented value equals the compare value, a match occurs. On a match the block can return the counter to zero, which gives a period of exactly `compare` strobes. Each match also bumps a small match tally and raises an interrupt pending flag.

Software reaches the block over a byte-wide register bus. The 32-bit registers are big-endian: the lowest byte address holds the most significant byte. The tally lives in the upper nibble of the control byte, so software can rebuild elapsed time without races. It reads the tally, then the counter, then the tally again. If the two tally reads differ, it reads the counter once more. An interrupt control byte holds the enable, the priority level and the pending flag, and drives the request and level outputs.

Top module: `tick_timer`

## Requirements
- R1: After reset every register reads zero: the counter, the compare register, the control byte at 0x17 and the interrupt byte at 0x1b. The output irq_req is 0 and irq_level is 0.
- R2: The compare register occupies byte addresses 0x04..0x07 and the counter occupies 0x08..0x0B. Within each register the lowest address holds bits 31:24 and the highest holds bits 7:0. A byte write replaces only its own byte, and reads return the same mapping.
- R3: The counter rises by exactly one in each cycle in which tick_stb is high and run (control bit 0) is 1. In every other cycle it holds its value.
- R4: A match is an increment whose result equals the compare value. On a match the counter loads 0 when auto-zero (control bit 1) is 1. When auto-zero is 0, the counter takes the incremented value.
- R5: Control bits 7:4 count matches and wrap from 15 to 0. Writes to these bits have no effect.
- R6: Writing a 1 to control bit 2 zeroes the match count, even when a match occurs in the same cycle. Control bit 2 always reads 0.
- R7: Every match sets the pending flag, read at bit 5 of 0x1b, whether or not the interrupt is enabled. Writing a 1 to bit 3 of 0x1b clears the flag. If a match occurs in the same cycle as that clear, the flag stays set. Bit 3 always reads 0.
- R8: The interrupt byte stores the enable at bit 4 and the level at bits 2:0. The output irq_req is high exactly when pending and enable are both 1, and irq_level follows bits 2:0.
- R9: A bus write to any counter byte takes priority over counting in that cycle. The counter then holds its old value with the written byte replaced, and no match is detected.
- R10: Addresses that map to no register read as 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_stb | input | 1 | Count-rate strobe, one clock wide per tick |
| bus_addr | input | 5 | Byte address |
| bus_wr | input | 1 | Write strobe for the addressed byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| irq_req | output | 1 | Interrupt request |
| irq_level | output | 3 | Interrupt priority level |

## Verification
The in-RTL properties check on every cycle that the counter steps by one or holds, and that auto-zero returns it to zero after a match. They also check that the match count increments or clears as required, and that the pending flag is set by a match and cleared by a lone clear. Only the bench scenarios can show the rest. These include the big-endian placement of the bytes and a carry moving across a byte boundary. They also include the 16-match wrap, the same-cycle collisions of a match with each clear, and counter-write priority over a strobe. The scenarios finally show that unmapped accesses leave every register untouched.

// File: rtl/tick_pkg.sv
package tick_pkg;
    localparam int BUS_AW   = 5;
    localparam int BYTE_W   = 8;
    // byte offsets of the register windows
    localparam int OFS_CMP  = 4;
    localparam int OFS_CNT  = 8;
    localparam int OFS_CTRL = 23;
    localparam int OFS_ICTL = 27;
    // control byte bit positions
    localparam int CTL_RUN  = 0;
    localparam int CTL_AUTOZ = 1;
    localparam int CTL_MCLR = 2;
    // interrupt byte bit positions
    localparam int ICT_CLR  = 3;
    localparam int ICT_EN   = 4;
    localparam int ICT_PEND = 5;
endpackage

// File: rtl/tick_bus_if.sv
module tick_bus_if
    import tick_pkg::*;
#(
    parameter int CNT_W = 32,
    localparam int NB   = CNT_W / BYTE_W
) (
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [CNT_W-1:0]  cmp_val,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic [BYTE_W-1:0] ctl_rd,
    input  logic [BYTE_W-1:0] ict_rd,
    output logic [NB-1:0]     cmp_we,
    output logic [NB-1:0]     cnt_we,
    output logic              ctl_we,
    output logic              ict_we,
    output logic [BYTE_W-1:0] bus_rdata
);
    always_comb begin
        bus_rdata = '0;
        cmp_we    = '0;
        cnt_we    = '0;
        ctl_we    = bus_wr && (bus_addr == BUS_AW'(OFS_CTRL));
        ict_we    = bus_wr && (bus_addr == BUS_AW'(OFS_ICTL));
        for (int i = 0; i < NB; i++) begin
            // lowest address carries the most significant byte
            if (bus_addr == BUS_AW'(OFS_CMP + i)) begin
                cmp_we[i] = bus_wr;
                bus_rdata = cmp_val[(NB-1-i)*BYTE_W +: BYTE_W];
            end
            if (bus_addr == BUS_AW'(OFS_CNT + i)) begin
                cnt_we[i] = bus_wr;
                bus_rdata = cnt_val[(NB-1-i)*BYTE_W +: BYTE_W];
            end
        end
        if (bus_addr == BUS_AW'(OFS_CTRL)) bus_rdata = ctl_rd;
        if (bus_addr == BUS_AW'(OFS_ICTL)) bus_rdata = ict_rd;
    end

    // R10: at most one register window answers a write
    always_comb begin
        wr_decode_chk: assert ($countones({cmp_we, cnt_we, ctl_we, ict_we}) <= 1);
    end
endmodule

// File: rtl/tick_counter.sv
module tick_counter
    import tick_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int MCNT_W = 4,
    localparam int NB   = CNT_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [NB-1:0]     cmp_we,
    input  logic [NB-1:0]     cnt_we,
    input  logic              ctl_we,
    input  logic [BYTE_W-1:0] wdata,
    output logic [CNT_W-1:0]  cnt_val,
    output logic [CNT_W-1:0]  cmp_val,
    output logic [BYTE_W-1:0] ctl_rd,
    output logic              match_o
);
    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  cmp;
        logic              run;
        logic              autoz;
        logic [MCNT_W-1:0] mcnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic [CNT_W-1:0] inc_val;
    logic             match_d;

    always_comb begin
        st_d    = st_q;
        match_d = 1'b0;
        inc_val = st_q.cnt + CNT_W'(1);
        for (int i = 0; i < NB; i++) begin
            if (cmp_we[i]) st_d.cmp[(NB-1-i)*BYTE_W +: BYTE_W] = wdata;
        end
        if (|cnt_we) begin
            for (int i = 0; i < NB; i++) begin
                if (cnt_we[i]) st_d.cnt[(NB-1-i)*BYTE_W +: BYTE_W] = wdata;
            end
        end else if (st_q.run && tick_i) begin
            if (inc_val == st_q.cmp) begin
                match_d  = 1'b1;
                st_d.cnt = st_q.autoz ? '0 : inc_val;
            end else begin
                st_d.cnt = inc_val;
            end
        end
        if (ctl_we) begin
            st_d.run   = wdata[CTL_RUN];
            st_d.autoz = wdata[CTL_AUTOZ];
        end
        if (ctl_we && wdata[CTL_MCLR]) st_d.mcnt = '0;
        else if (match_d)               st_d.mcnt = st_q.mcnt + MCNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_val = st_q.cnt;
    assign cmp_val = st_q.cmp;
    assign match_o = match_d;
    assign ctl_rd  = {st_q.mcnt, {(BYTE_W-MCNT_W-2){1'b0}}, st_q.autoz, st_q.run};

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && tick_i && !(|cnt_we) && !st_q.autoz)
        |=> (cnt_val == $past(cnt_val) + CNT_W'(1)));
    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(st_q.run && tick_i) && !(|cnt_we)) |=> $stable(cnt_val));
    // R4
    autoz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o && st_q.autoz) |=> (cnt_val == '0));
    // R5
    mcnt_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o && !(ctl_we && wdata[CTL_MCLR]))
        |=> (ctl_rd[BYTE_W-1 -: MCNT_W] == $past(ctl_rd[BYTE_W-1 -: MCNT_W]) + MCNT_W'(1)));
    // R6
    mcnt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && wdata[CTL_MCLR]) |=> (ctl_rd[BYTE_W-1 -: MCNT_W] == '0));
    // R9
    wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|cnt_we) |-> !match_o);
endmodule

// File: rtl/tick_irq_ctl.sv
module tick_irq_ctl
    import tick_pkg::*;
#(
    parameter int LVL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              match_i,
    input  logic              we_i,
    input  logic [ICT_EN:0]   wdata_i,
    output logic [BYTE_W-1:0] ict_rd,
    output logic              irq_req_o,
    output logic [LVL_W-1:0]  irq_lvl_o
);
    typedef struct packed {
        logic             pend;
        logic             en;
        logic [LVL_W-1:0] lvl;
    } ict_st_t;

    ict_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            st_d.en  = wdata_i[ICT_EN];
            st_d.lvl = wdata_i[LVL_W-1:0];
        end
        // a match wins over a same-cycle clear
        if (match_i)                       st_d.pend = 1'b1;
        else if (we_i && wdata_i[ICT_CLR]) st_d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_req_o = st_q.pend & st_q.en;
    assign irq_lvl_o = st_q.lvl;
    assign ict_rd    = {{(BYTE_W-ICT_PEND-1){1'b0}}, st_q.pend, st_q.en,
                        {(ICT_EN-LVL_W){1'b0}}, st_q.lvl};

    // R7
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_i |=> ict_rd[ICT_PEND]);
    // R7
    pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && wdata_i[ICT_CLR] && !match_i) |=> !ict_rd[ICT_PEND]);
    // R8
    req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !wdata_i[ICT_EN]) |=> !irq_req_o);
endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int MCNT_W = 4,
    parameter int LVL_W  = 3,
    localparam int NB    = CNT_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_stb,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              irq_req,
    output logic [LVL_W-1:0]  irq_level
);
    logic [NB-1:0]     cmp_we, cnt_we;
    logic              ctl_we, ict_we, match;
    logic [CNT_W-1:0]  cnt_val, cmp_val;
    logic [BYTE_W-1:0] ctl_rd, ict_rd;

    tick_bus_if #(.CNT_W(CNT_W)) u_bus (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .cmp_val  (cmp_val),
        .cnt_val  (cnt_val),
        .ctl_rd   (ctl_rd),
        .ict_rd   (ict_rd),
        .cmp_we   (cmp_we),
        .cnt_we   (cnt_we),
        .ctl_we   (ctl_we),
        .ict_we   (ict_we),
        .bus_rdata(bus_rdata)
    );

    tick_counter #(.CNT_W(CNT_W), .MCNT_W(MCNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_stb),
        .cmp_we (cmp_we),
        .cnt_we (cnt_we),
        .ctl_we (ctl_we),
        .wdata  (bus_wdata),
        .cnt_val(cnt_val),
        .cmp_val(cmp_val),
        .ctl_rd (ctl_rd),
        .match_o(match)
    );

    tick_irq_ctl #(.LVL_W(LVL_W)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .match_i  (match),
        .we_i     (ict_we),
        .wdata_i  (bus_wdata[ICT_EN:0]),
        .ict_rd   (ict_rd),
        .irq_req_o(irq_req),
        .irq_lvl_o(irq_level)
    );
endmodule

// File: tb/tb_tick_timer.sv
module tb_tick_timer;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 15;
    // {write, addr, data, expected read}
    localparam logic [21:0] VEC [0:NV-1] = '{
        {1'b1, 5'h04, 8'h12, 8'h00},
        {1'b1, 5'h05, 8'h34, 8'h00},
        {1'b1, 5'h06, 8'h56, 8'h00},
        {1'b1, 5'h07, 8'h78, 8'h00},
        {1'b0, 5'h04, 8'h00, 8'h12},
        {1'b0, 5'h07, 8'h00, 8'h78},
        {1'b1, 5'h08, 8'hAB, 8'h00},
        {1'b1, 5'h0B, 8'hCD, 8'h00},
        {1'b0, 5'h08, 8'h00, 8'hAB},
        {1'b0, 5'h0B, 8'h00, 8'hCD},
        {1'b0, 5'h09, 8'h00, 8'h00},
        {1'b1, 5'h10, 8'hFF, 8'h00},
        {1'b0, 5'h10, 8'h00, 8'h00},
        {1'b1, 5'h1B, 8'h3F, 8'h00},
        {1'b0, 5'h1B, 8'h00, 8'h17}
    };

    logic clk = 1'b0, rst_n = 1'b0, tick_stb = 1'b0, bus_wr = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic irq_req;
    logic [2:0] irq_level;
    int n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tick_timer dut (.clk(clk), .rst_n(rst_n), .tick_stb(tick_stb), .bus_addr(bus_addr),
                    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
                    .irq_req(irq_req), .irq_level(irq_level));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr8(input logic [4:0] a, input logic [7:0] d, input logic tk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick_stb = tk;
        @(negedge clk);
        bus_wr = 1'b0; tick_stb = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick_stb = 1'b1;
            @(negedge clk); tick_stb = 1'b0;
        end
    endtask

    task automatic rd8(input logic [4:0] a, output logic [7:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic rd32(input logic [4:0] base, output logic [31:0] v);
        logic [7:0] b;
        for (int i = 0; i < 4; i++) begin
            rd8(base + 5'(i), b);
            v = {v[23:0], b};
        end
    endtask

    task automatic wr32(input logic [4:0] base, input logic [31:0] v);
        for (int i = 0; i < 4; i++) wr8(base + 5'(i), v[31-8*i -: 8], 1'b0);
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual expired expected completion");
        report();
    end

    initial begin
        logic [7:0] b;
        logic [31:0] w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd32(5'h08, w); chk("R1 counter", w, 0);
        rd32(5'h04, w); chk("R1 compare", w, 0);
        rd8(5'h17, b); chk("R1 control", b, 0);
        rd8(5'h1B, b); chk("R1 irq byte", b, 0);
        chk("R1 irq_req", irq_req, 0);
        chk("R1 irq_level", irq_level, 0);

        // R2 R10 R8 table walk
        for (int v = 0; v < NV; v++) begin
            if (VEC[v][21]) wr8(VEC[v][20:16], VEC[v][15:8], 1'b0);
            else begin
                rd8(VEC[v][20:16], b);
                chk($sformatf("R2/R8/R10 vector %0d", v), b, VEC[v][7:0]);
            end
        end
        chk("R8 level from table", irq_level, 3'd7);
        wr8(5'h1B, 8'h00, 1'b0);

        // R2 carry crosses byte lanes in big-endian order
        wr32(5'h08, 32'h000000FF);
        wr8(5'h17, 8'h01, 1'b0);
        ticks(1);
        rd8(5'h0A, b); chk("R2 carry byte 0x0A", b, 8'h01);
        rd8(5'h0B, b); chk("R2 carry byte 0x0B", b, 8'h00);
        // R3 hold while stopped
        wr8(5'h17, 8'h00, 1'b0);
        ticks(3);
        rd32(5'h08, w); chk("R3 hold when stopped", w, 32'h100);

        // R3 R4 R5 R7 periodic match with auto-zero
        wr32(5'h04, 32'd5);
        wr32(5'h08, 32'd0);
        wr8(5'h17, 8'h03, 1'b0);
        ticks(4);
        rd32(5'h08, w); chk("R3 count 4", w, 4);
        rd8(5'h1B, b); chk("R7 no pending yet", b, 8'h00);
        ticks(1);
        rd32(5'h08, w); chk("R4 auto-zero", w, 0);
        rd8(5'h17, b); chk("R5 match count 1", b, 8'h13);
        rd8(5'h1B, b); chk("R7 pending while disabled", b, 8'h20);
        chk("R7 no request while disabled", irq_req, 0);

        // R8 enable and level
        wr8(5'h1B, 8'h15, 1'b0);
        chk("R8 request", irq_req, 1);
        chk("R8 level", irq_level, 3'd5);
        rd8(5'h1B, b); chk("R8 read back", b, 8'h35);
        wr8(5'h1B, 8'h1D, 1'b0);
        rd8(5'h1B, b); chk("R7 clear pending", b, 8'h15);
        chk("R7 request drops", irq_req, 0);

        // R5 wrap after 15 more matches
        ticks(75);
        rd8(5'h17, b); chk("R5 wrap to zero", b, 8'h03);
        chk("R8 request on new match", irq_req, 1);

        // R6 clear with simultaneous match
        ticks(5);
        wr8(5'h1B, 8'h1D, 1'b0);
        wr8(5'h0B, 8'h04, 1'b0);
        wr8(5'h17, 8'h07, 1'b1);
        rd8(5'h17, b); chk("R6 clear beats match, bit2 reads 0", b, 8'h03);
        rd32(5'h08, w); chk("R4 counter after collided match", w, 0);
        rd8(5'h1B, b); chk("R7 match sets pending", b, 8'h35);
        ticks(5);
        wr8(5'h17, 8'h07, 1'b0);
        rd8(5'h17, b); chk("R6 plain clear", b, 8'h03);

        // R7 match beats same-cycle clear
        wr8(5'h0B, 8'h04, 1'b0);
        wr8(5'h1B, 8'h1D, 1'b1);
        rd8(5'h1B, b); chk("R7 match keeps pending", b, 8'h35);

        // R4 no auto-zero
        wr8(5'h17, 8'h01, 1'b0);
        wr8(5'h0B, 8'h03, 1'b0);
        ticks(2);
        rd32(5'h08, w); chk("R4 reaches compare", w, 5);
        rd8(5'h17, b); chk("R5 count 2", b, 8'h21);
        ticks(1);
        rd32(5'h08, w); chk("R4 runs past compare", w, 6);

        // R9 write priority
        wr8(5'h0B, 8'h20, 1'b1);
        rd32(5'h08, w); chk("R9 write beats tick", w, 32'h20);

        // R10 unmapped write ignored
        wr8(5'h00, 8'hFF, 1'b0);
        wr8(5'h1F, 8'hFF, 1'b0);
        rd8(5'h00, b); chk("R10 unmapped reads 0", b, 0);
        rd8(5'h17, b); chk("R10 control unchanged", b, 8'h21);
        rd8(5'h1B, b); chk("R10 irq byte unchanged", b, 8'h35);
        rd32(5'h04, w); chk("R10 compare unchanged", w, 5);
        rd32(5'h08, w); chk("R10 counter unchanged", w, 32'h20);
        report();
    end
endmodule